// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Holding Register

This block takes asynchronous serial characters from a single input line and turns them into parallel words for a host. It runs from a local clock at sixteen times the bit rate. A high-to-low transition on the idle-high line is taken as a possible start bit. The line is checked again half a bit period later to confirm it. After that, the block samples each data bit, an optional parity bit and the stop bit once per bit period, near the centre of each cell.

Data bits collect in a shift register. When the stop bit has been sampled, the finished character moves into a separate holding register. The next character can then arrive while the host still has the previous one. Along with the character, the block captures a parity status flag and a framing status flag. A ready flag tells the host that a new word is waiting. The host reads by pulling an active-low strobe. While the strobe is low, the held word appears on the output bus, and the read also clears the ready flag.

Top module: `serial_rx_core`

## Requirements
- R1: A character is started only by a falling edge of `rxd`, meaning high at one clock edge and low at the next. A line that stays low, for example after a bad stop bit, starts nothing until it has gone high and then falls again.
- R2: The line is sampled at the 8th clock edge after the edge that first saw it low. If it is high there, the start is discarded: the receiver returns to hunting and loads nothing.
- R3: Each data bit is sampled 16 clocks after the previous sample. The bits are received least significant bit first, and the completed word equals the transmitted value.
- R4: With parity on (the default), one parity bit follows the data bits, and the stop bit follows that. The character is loaded at the clock edge 8 + 16 × (DATA_BITS + 2) clocks after the edge that first saw the line low. With the default settings that is 168 clocks.
- R5: `parity_err` is loaded as 1 when the XOR of the data bits and the received parity bit differs from PARITY_ODD. The default is PARITY_ODD = 0, which is even parity.
- R6: `frame_err` is loaded as 1 when the sampled stop bit is low, and as 0 when it is high.
- R7: `parity_err` and `frame_err` change only when a character is loaded. Reads leave them unchanged.
- R8: `data_ready` goes to 1 at the load edge. It goes to 0 at a clock edge where `rd_n` is low and no load happens. When both happen at the same edge, the load wins.
- R9: `dout` shows the held word while `rd_n` is low. While `rd_n` is high, `dout` is all zeros.
- R10: The held word does not change while the next character shifts in. A newly completed character replaces it whether or not it was read.
- R11: A synchronous `rst` clears the held word, `data_ready`, `parity_err` and `frame_err`. It also returns the receiver to hunting for a start, so a character that was in progress is never loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial line, idle high |
| rd_n | input | 1 | Host read strobe, active low |
| dout | output | DATA_BITS | Held word while `rd_n` is low, zeros otherwise |
| data_ready | output | 1 | A new word is waiting in the holding register |
| parity_err | output | 1 | Parity status of the held word |
| frame_err | output | 1 | Framing status of the held word |

## Verification
The checks assume the following about the inputs:
- `rxd` is already synchronous to `clk` and changes only between edges.
- Each bit cell lasts exactly 16 clocks.
- The host pulls `rd_n` low only while `data_ready` is high.

The stimulus keeps within these limits. It drives `rxd` and `rd_n` shortly after each falling clock edge and holds every line bit for 16 clocks. It issues reads only after a character is known to be loaded. The one deliberate read at the load edge also falls while an earlier word is still waiting.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic half_hit,
    output logic full_hit
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    logic [CW-1:0] cnt_d, cnt_q;

    // Counter sits at zero while hunting and restarts after every sample.
    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run || restart) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign half_hit = run && (cnt_q == CW'(HALF - 1));
    assign full_hit = run && (cnt_q == CW'(OSR - 1));
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    input  logic                 half_hit,
    input  logic                 full_hit,
    output logic                 run,
    output logic                 restart,
    output logic                 load,
    output logic [DATA_BITS-1:0] load_data,
    output logic                 load_perr,
    output logic                 load_ferr
);
    localparam int   BCW     = $clog2(DATA_BITS + 1);
    localparam logic ODD_BIT = (PARITY_ODD != 0);
    localparam logic PAR_ON  = (PARITY_EN != 0);

    typedef struct packed {
        rx_state_e            state;
        logic [BCW-1:0]       bitcnt;
        logic [DATA_BITS-1:0] shreg;
        logic                 par;
        logic                 prev;
    } fsm_t;

    fsm_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.prev = rxd;
        load     = 1'b0;
        restart  = 1'b0;
        unique case (r_q.state)
            ST_HUNT: begin
                if (r_q.prev && !rxd) r_d.state = ST_START;
            end
            ST_START: begin
                if (half_hit) begin
                    restart = 1'b1;
                    if (rxd) begin
                        r_d.state = ST_HUNT;
                    end else begin
                        r_d.state  = ST_DATA;
                        r_d.bitcnt = '0;
                    end
                end
            end
            ST_DATA: begin
                if (full_hit) begin
                    restart    = 1'b1;
                    r_d.shreg  = {rxd, r_q.shreg[DATA_BITS-1:1]};
                    r_d.bitcnt = r_q.bitcnt + 1'b1;
                    if (r_q.bitcnt == BCW'(DATA_BITS - 1))
                        r_d.state = PAR_ON ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (full_hit) begin
                    restart   = 1'b1;
                    r_d.par   = rxd;
                    r_d.state = ST_STOP;
                end
            end
            ST_STOP: begin
                if (full_hit) begin
                    restart   = 1'b1;
                    load      = 1'b1;
                    r_d.state = ST_HUNT;
                end
            end
            default: r_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state  <= ST_HUNT;
            r_q.bitcnt <= '0;
            r_q.shreg  <= '0;
            r_q.par    <= 1'b0;
            r_q.prev   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign run       = (r_q.state != ST_HUNT);
    assign load_data = r_q.shreg;
    assign load_ferr = !rxd;
    assign load_perr = PAR_ON ? ((^r_q.shreg) ^ r_q.par ^ ODD_BIT) : 1'b0;
endmodule

// File: rtl/srx_hold_reg.sv
module srx_hold_reg #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_data,
    input  logic                 load_perr,
    input  logic                 load_ferr,
    input  logic                 rd_n,
    output logic [DATA_BITS-1:0] hold_data,
    output logic                 ready,
    output logic                 perr,
    output logic                 ferr
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 ready;
        logic                 perr;
        logic                 ferr;
    } hold_t;

    hold_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (!rd_n) h_d.ready = 1'b0;
        if (load) begin
            h_d.data  = load_data;
            h_d.ready = 1'b1;
            h_d.perr  = load_perr;
            h_d.ferr  = load_ferr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) h_q <= '0;
        else     h_q <= h_d;
    end

    assign hold_data = h_q.data;
    assign ready     = h_q.ready;
    assign perr      = h_q.perr;
    assign ferr      = h_q.ferr;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int DATA_BITS  = 8,
    parameter int OSR        = 16,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    input  logic                 rd_n,
    output logic [DATA_BITS-1:0] dout,
    output logic                 data_ready,
    output logic                 parity_err,
    output logic                 frame_err
);
    logic                 tmr_run, tmr_restart, half_hit, full_hit;
    logic                 frame_load, frame_perr, frame_ferr;
    logic [DATA_BITS-1:0] frame_data, hold_data;

    srx_bit_timer #(.OSR(OSR)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (tmr_run),
        .restart  (tmr_restart),
        .half_hit (half_hit),
        .full_hit (full_hit)
    );

    srx_frame_fsm #(
        .DATA_BITS  (DATA_BITS),
        .PARITY_EN  (PARITY_EN),
        .PARITY_ODD (PARITY_ODD)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rxd       (rxd),
        .half_hit  (half_hit),
        .full_hit  (full_hit),
        .run       (tmr_run),
        .restart   (tmr_restart),
        .load      (frame_load),
        .load_data (frame_data),
        .load_perr (frame_perr),
        .load_ferr (frame_ferr)
    );

    srx_hold_reg #(.DATA_BITS(DATA_BITS)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_load),
        .load_data (frame_data),
        .load_perr (frame_perr),
        .load_ferr (frame_ferr),
        .rd_n      (rd_n),
        .hold_data (hold_data),
        .ready     (data_ready),
        .perr      (parity_err),
        .ferr      (frame_err)
    );

    assign dout = rd_n ? '0 : hold_data;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_n,
    input logic                 load,
    input logic [DATA_BITS-1:0] hold_data,
    input logic                 data_ready,
    input logic                 parity_err,
    input logic                 frame_err
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!data_ready && !parity_err && !frame_err && hold_data == '0)); // R11

    AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (rst)
        load |=> data_ready); // R8

    AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !load) |=> !data_ready); // R8

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(parity_err) && $stable(frame_err))); // R7

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold_data)); // R10
endmodule

bind serial_rx_core srx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_n       (rd_n),
    .load       (frame_load),
    .hold_data  (hold_data),
    .data_ready (data_ready),
    .parity_err (parity_err),
    .frame_err  (frame_err)
);

// File: tb/sim_serial_rx_core.sv
`timescale 1ns/1ps
module sim_serial_rx_core;
    localparam int NB       = 8;
    localparam int LOAD_LAT = 8 + 16 * (NB + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rxd = 1'b1;
    logic          rd_n = 1'b1;
    logic [NB-1:0] dout;
    logic          data_ready, parity_err, frame_err;

    serial_rx_core u0 (
        .clk        (clk),
        .rst        (rst),
        .rxd        (rxd),
        .rd_n       (rd_n),
        .dout       (dout),
        .data_ready (data_ready),
        .parity_err (parity_err),
        .frame_err  (frame_err)
    );

    always #2.5 clk = ~clk;

    int    cyc = 0;
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur_req = "R11";

    // Behavioural reference: pending loads are queued with their due cycle.
    logic [NB-1:0] m_data = '0;
    logic          m_rdy = 1'b0, m_perr = 1'b0, m_ferr = 1'b0;
    int            ev_cyc[$];
    logic [NB-1:0] ev_data[$];
    bit            ev_perr[$];
    bit            ev_ferr[$];

    always @(posedge clk) begin
        if (rst) begin
            m_data <= '0; m_rdy <= 1'b0; m_perr <= 1'b0; m_ferr <= 1'b0;
        end else begin
            if (!rd_n) m_rdy <= 1'b0;
            if (ev_cyc.size() > 0 && ev_cyc[0] == cyc) begin
                void'(ev_cyc.pop_front());
                m_data <= ev_data.pop_front();
                m_perr <= ev_perr.pop_front();
                m_ferr <= ev_ferr.pop_front();
                m_rdy  <= 1'b1;
            end
        end
        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        logic [NB-1:0] exp_dout;
        exp_dout = rd_n ? '0 : m_data;
        vectors++;
        if (dout !== exp_dout || data_ready !== m_rdy ||
            parity_err !== m_perr || frame_err !== m_ferr) begin
            miscompares++;
            $display("FAIL %s cyc=%0d dout=%h/%h ready=%b/%b perr=%b/%b ferr=%b/%b (actual/expected)",
                     cur_req, cyc, dout, exp_dout, data_ready, m_rdy,
                     parity_err, m_perr, frame_err, m_ferr);
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic send_char(input logic [NB-1:0] d, input bit bad_par, input bit stop_hi);
        tick();
        rxd = 1'b0;
        ev_cyc.push_back(cyc + LOAD_LAT);
        ev_data.push_back(d);
        ev_perr.push_back(bad_par);
        ev_ferr.push_back(!stop_hi);
        repeat (16) tick();
        for (int i = 0; i < NB; i++) begin
            rxd = d[i];
            repeat (16) tick();
        end
        rxd = (^d) ^ bad_par;
        repeat (16) tick();
        rxd = stop_hi;
        repeat (16) tick();
    endtask

    task automatic do_read();
        tick();
        rd_n = 1'b0;
        tick();
        rd_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL %s watchdog expired actual=running expected=finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        cur_req = "R11";
        idle(5);
        rst = 1'b0;
        idle(10);

        // R3 R4 R9: several data patterns, each read back
        cur_req = "R3";
        send_char(8'hA5, 1'b0, 1'b1); idle(5); do_read();
        send_char(8'h00, 1'b0, 1'b1); idle(3); do_read();
        send_char(8'hFF, 1'b0, 1'b1); idle(3); do_read();
        cur_req = "R4";
        send_char(8'h01, 1'b0, 1'b1); idle(2); do_read();
        cur_req = "R9";
        send_char(8'h80, 1'b0, 1'b1); idle(7); do_read(); idle(4);

        // R5: wrong parity bit, then R7: flag survives a read, cleared by next good char
        cur_req = "R5";
        send_char(8'h5A, 1'b1, 1'b1); idle(4);
        cur_req = "R7";
        do_read(); idle(20);
        send_char(8'h3C, 1'b0, 1'b1); idle(4); do_read();

        // R6: low stop bit, line then held low; R1: no restart on a held-low line
        cur_req = "R6";
        send_char(8'hC3, 1'b0, 1'b0);
        cur_req = "R1";
        idle(40);
        rxd = 1'b1;
        idle(250);
        do_read(); idle(5);

        // R2: short low pulse is discarded
        cur_req = "R2";
        tick(); rxd = 1'b0; idle(4); rxd = 1'b1; idle(200);
        tick(); rxd = 1'b0; idle(7); rxd = 1'b1; idle(200);

        // R10: held word is read while the next character shifts in
        cur_req = "R10";
        send_char(8'h96, 1'b0, 1'b1); idle(2);
        fork
            send_char(8'h69, 1'b0, 1'b1);
            begin idle(60); do_read(); end
        join
        idle(3);
        // overwrite without read
        send_char(8'h12, 1'b0, 1'b1); idle(3); do_read(); idle(3);

        // R8: read strobe at the very edge a new character loads; load wins
        cur_req = "R8";
        send_char(8'h7E, 1'b0, 1'b1); idle(2);
        fork
            send_char(8'hE7, 1'b0, 1'b1);
            begin idle(1 + LOAD_LAT); rd_n = 1'b0; tick(); rd_n = 1'b1; end
        join
        idle(5); do_read(); idle(5);

        // R11: reset in mid-character clears state and drops the character
        cur_req = "R11";
        send_char(8'h44, 1'b0, 1'b1); idle(2);
        tick(); rxd = 1'b0; idle(40);
        rst = 1'b1; rxd = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(250);
        send_char(8'hB2, 1'b0, 1'b1); idle(3); do_read(); idle(5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule